// File: doc/BRIEF.md
# Pipe Colour Matrix Converter

This block sits in a display pipe and applies a programmable 3x3 colour matrix to every pixel. Each of the three 10-bit components first receives a signed pre-offset. The three offset components are then multiplied by nine coefficients, each output channel sums its three products, a post-offset is added, and the result is rounded and saturated back to 10 bits. Its main use is squeezing full-range RGB (0..1023) into the limited video range. A unity matrix with zero offsets gives an exact pass-through.

Each incoming pixel carries its own convert select, supplied by whichever plane or cursor produced it. A pixel with the select low skips the matrix but keeps the same latency. Software programs thirteen 32-bit words through a simple write/read port. Those words land in a staged copy and only reach the datapath on a frame-start pulse, so every frame is converted with one consistent setting.

Top module: `pipe_csc`

## Requirements
- R1: After reset, `out_valid` is 0 and the live and staged settings are both a unity matrix: word 0 reads 0x78000000, word 2 reads 0x00007800, word 5 reads 0x78000000, every other word reads 0, and converted pixels come out unchanged.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock cycles, with no gaps or bubbles added.
- R3: A pixel taken with `in_csc_en` = 0 comes out three cycles later bit-identical to its input, whatever the settings are.
- R4: Register word map. Words 0/1 hold matrix row 0, words 2/3 row 1, and words 4/5 row 2. An even word holds column 0 in bits 31:16 and column 1 in bits 15:0. An odd word holds column 2 in bits 31:16, and its bits 15:0 are dropped and read 0. Word 6 is the mode (bits 2:0). Words 7..9 are the pre-offsets and words 10..12 the post-offsets of channels 0..2, 13 bits each in bits 12:0. Words 13..15 ignore writes and read 0. Reads return the staged copy.
- R5: A write changes only the staged copy. The datapath switches to the staged copy on the clock edge that samples `frame_start` = 1, and never at any other time.
- R6: Coefficient format: bit 15 is the sign and bits 14:12 are the exponent. Bits 11:3 are a 9-bit magnitude m, and bits 2:0 are ignored. Exponent 0 gives m/512, exponent 7 gives m/256, and any other exponent gives 0.
- R7: For channel k (bits 10k+9:10k of the pixel buses) the block computes: round-half-up of sum over j of (8*x_j + pre_j)*c_kj/8 plus post_k/8. Here pre_j is a 13-bit two's-complement value and post_k is 13-bit unsigned.
- R8: When mode bit 2 is set, every channel uses a fixed post-offset of 514 (a 16-code lift at 8-bit scale) in place of words 10..12. Mode bits 1:0 are stored and read back but do not change the datapath.
- R9: Results below 0 come out as 0, and results above 1023 come out as 1023.
- R10: With 0x0DB8 on the diagonal, zero off-diagonal terms, zero pre-offsets and post-offsets of 514, input 0 maps to 64 and input 1023 maps to 941.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Staged value of the indexed word (combinational) |
| frame_start | input | 1 | Copies the staged settings into the live settings |
| in_valid | input | 1 | Input pixel valid |
| in_csc_en | input | 1 | 1: convert this pixel, 0: bypass the matrix |
| in_pix | input | 3*CW | Input pixel, channel k in bits CW*k+CW-1:CW*k |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 3*CW | Output pixel, same packing as `in_pix` |

## Verification
The bench builds the block with its default component width of 10 bits, the width the arithmetic rules and register scaling above are written for. At this width the whole output code range is reachable. Random coefficients, including negative and reserved-exponent codes, and random signed pre-offsets push results past both 0 and 1023. The directed settings (unity, limited-range compression, black lift through the mode bit, deliberate over- and underflow) are therefore only a small part of the space that the random settings cover.

// File: rtl/pipe_csc_pkg.sv
package pipe_csc_pkg;
  localparam int NCH       = 3;
  localparam int COEF_W    = 16;
  localparam int OFS_W     = 13;
  localparam int FIX_W     = 12;   // signed coefficient in 1/512 units
  localparam int COEF_FRAC = 9;
  localparam int PIX_FRAC  = 3;    // offsets carry three bits below the pixel LSB
  localparam int MODE_W    = 3;
  localparam int MODE_BLACK = 2;
  localparam logic [COEF_W-1:0] COEF_ONE   = 16'h7800;
  localparam logic [OFS_W-1:0]  BLACK_LIFT = OFS_W'(16 * 8192 / 255);

  typedef logic [COEF_W-1:0] coef_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  typedef struct packed {
    coef_t [NCH-1:0][NCH-1:0] coef;   // [row][column]
    logic  [MODE_W-1:0]       mode;
    ofs_t  [NCH-1:0]          pre;
    ofs_t  [NCH-1:0]          post;
  } csc_cfg_t;

  // sign / exponent / mantissa to signed fixed point, 1/512 units
  function automatic logic signed [FIX_W-1:0] coef_fix(coef_t c);
    logic [FIX_W-1:0] mag;
    case (c[14:12])
      3'd0:    mag = {3'b000, c[11:3]};
      3'd7:    mag = {2'b00, c[11:3], 1'b0};
      default: mag = '0;
    endcase
    return c[15] ? -$signed(mag) : $signed(mag);
  endfunction

  function automatic csc_cfg_t unity_cfg();
    csc_cfg_t c;
    c = '0;
    for (int i = 0; i < NCH; i++) c.coef[i][i] = COEF_ONE;
    return c;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import pipe_csc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  idx,
  input  logic [31:0] wdata,
  input  logic        frame_start,
  output logic [31:0] rdata,
  output csc_cfg_t    active
);
  localparam logic [3:0] I_ROWS = 4'd6;
  localparam logic [3:0] I_MODE = 4'd6;
  localparam logic [3:0] I_PRE  = 4'd7;
  localparam logic [3:0] I_POST = 4'd10;
  localparam logic [3:0] I_END  = 4'd13;

  csc_cfg_t staged_q, staged_d, active_q;
  logic [1:0] row_sel, pre_sel, post_sel;

  assign row_sel  = idx[2:1];
  assign pre_sel  = 2'(idx - I_PRE);
  assign post_sel = 2'(idx - I_POST);

  always_comb begin
    staged_d = staged_q;
    if (we) begin
      if (idx < I_ROWS) begin
        if (!idx[0]) begin
          staged_d.coef[row_sel][0] = wdata[31:16];
          staged_d.coef[row_sel][1] = wdata[15:0];
        end else begin
          staged_d.coef[row_sel][2] = wdata[31:16];
        end
      end else if (idx == I_MODE) staged_d.mode = wdata[MODE_W-1:0];
      else if (idx < I_POST)      staged_d.pre[pre_sel] = wdata[OFS_W-1:0];
      else if (idx < I_END)       staged_d.post[post_sel] = wdata[OFS_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (idx < I_ROWS) begin
      if (!idx[0]) rdata = {staged_q.coef[row_sel][0], staged_q.coef[row_sel][1]};
      else         rdata = {staged_q.coef[row_sel][2], 16'h0000};
    end else if (idx == I_MODE) rdata = 32'(staged_q.mode);
    else if (idx < I_POST)      rdata = 32'(staged_q.pre[pre_sel]);
    else if (idx < I_END)       rdata = 32'(staged_q.post[post_sel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= unity_cfg();
      active_q <= unity_cfg();
    end else begin
      staged_q <= staged_d;
      if (frame_start) active_q <= staged_q;
    end
  end

  assign active = active_q;

  // R5: live settings only move on a frame-start pulse
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q));
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> active_q == $past(staged_q));
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import pipe_csc_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  csc_cfg_t        cfg,
  input  logic            in_valid,
  input  logic            in_csc_en,
  input  logic [3*CW-1:0] in_pix,
  output logic            out_valid,
  output logic [3*CW-1:0] out_pix
);
  localparam int PW    = NCH * CW;
  localparam int PS_W  = ((CW + PIX_FRAC > OFS_W) ? CW + PIX_FRAC : OFS_W) + 2;
  localparam int PR_W  = PS_W + FIX_W;
  localparam int ACC_W = PR_W + 3;
  localparam int FRAC  = PIX_FRAC + COEF_FRAC;
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1 << (FRAC - 1));
  localparam logic signed [ACC_W-1:0] TOP_CODE = ACC_W'((1 << CW) - 1);

  // stage 1: pre-offset
  logic signed [PS_W-1:0] ps1 [NCH];
  logic          v1, byp1;
  logic [PW-1:0] raw1;
  // stage 2: products
  logic signed [PR_W-1:0] prod2 [NCH][NCH];
  logic [OFS_W-1:0]       off2 [NCH];
  logic          v2, byp2;
  logic [PW-1:0] raw2;
  // stage 3 combinational view, named for the checks
  logic signed [ACC_W-1:0] s3_acc [NCH];
  logic signed [ACC_W-1:0] s3_res [NCH];
  logic [NCH-1:0]          s3_under, s3_over;
  logic [CW-1:0]           s3_clamp [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; byp1 <= 1'b0; raw1 <= '0;
      for (int ch = 0; ch < NCH; ch++) ps1[ch] <= '0;
    end else begin
      v1   <= in_valid;
      byp1 <= !in_csc_en;
      raw1 <= in_pix;
      for (int ch = 0; ch < NCH; ch++)
        ps1[ch] <= PS_W'($signed({1'b0, in_pix[ch*CW +: CW], {PIX_FRAC{1'b0}}}))
                 + PS_W'($signed(cfg.pre[ch]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; byp2 <= 1'b0; raw2 <= '0;
      for (int r = 0; r < NCH; r++) begin
        off2[r] <= '0;
        for (int c = 0; c < NCH; c++) prod2[r][c] <= '0;
      end
    end else begin
      v2   <= v1;
      byp2 <= byp1;
      raw2 <= raw1;
      for (int r = 0; r < NCH; r++) begin
        off2[r] <= cfg.mode[MODE_BLACK] ? BLACK_LIFT : cfg.post[r];
        for (int c = 0; c < NCH; c++)
          prod2[r][c] <= PR_W'(ps1[c]) * PR_W'(coef_fix(cfg.coef[r][c]));
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NCH; r++) begin
      s3_acc[r] = ACC_W'(prod2[r][0]) + ACC_W'(prod2[r][1]) + ACC_W'(prod2[r][2])
                + ACC_W'($signed({1'b0, off2[r], {COEF_FRAC{1'b0}}})) + RND_HALF;
      s3_res[r]   = s3_acc[r] >>> FRAC;
      s3_under[r] = s3_res[r][ACC_W-1];
      s3_over[r]  = !s3_res[r][ACC_W-1] && (s3_res[r] > TOP_CODE);
      s3_clamp[r] = s3_under[r] ? '0 : (s3_over[r] ? '1 : s3_res[r][CW-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v2;
      for (int r = 0; r < NCH; r++)
        out_pix[r*CW +: CW] <= byp2 ? raw2[r*CW +: CW] : s3_clamp[r];
    end
  end

  // cycles since reset, so three-deep history is only used once it exists
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && !in_csc_en, 3)) |-> out_pix == $past(in_pix, 3));

  for (genvar r = 0; r < NCH; r++) begin : g_sat_chk
    p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !byp2 && s3_under[r]) |=> out_pix[r*CW +: CW] == '0);
    p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !byp2 && s3_over[r]) |=> &out_pix[r*CW +: CW]);
  end
endmodule

// File: rtl/pipe_csc.sv
module pipe_csc
  import pipe_csc_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_idx,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            frame_start,
  input  logic            in_valid,
  input  logic            in_csc_en,
  input  logic [3*CW-1:0] in_pix,
  output logic            out_valid,
  output logic [3*CW-1:0] out_pix
);
  csc_cfg_t live_cfg;

  csc_cfg_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .idx         (cfg_idx),
    .wdata       (cfg_wdata),
    .frame_start (frame_start),
    .rdata       (cfg_rdata),
    .active      (live_cfg)
  );

  csc_datapath #(.CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (live_cfg),
    .in_valid  (in_valid),
    .in_csc_en (in_csc_en),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );
endmodule

// File: tb/pipe_csc_tb.sv
module pipe_csc_tb;
  localparam int CW = 10;
  localparam int PW = 3 * CW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we, frame_start, in_valid, in_csc_en, out_valid;
  logic [3:0] cfg_idx;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [PW-1:0] in_pix, out_pix;

  pipe_csc #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .in_valid(in_valid), .in_csc_en(in_csc_en), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench copy of staged (s_) and live (a_) settings
  logic [15:0] s_coef [3][3], a_coef [3][3];
  logic [12:0] s_pre [3], a_pre [3], s_post [3], a_post [3];
  logic [2:0]  s_mode, a_mode;

  // expected outputs for the three pixels in flight
  logic          hv [3];
  logic [PW-1:0] hp [3];
  string         hr [3];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // value of a coefficient in 1/512 steps
  function automatic longint coef_val(logic [15:0] c);
    longint m = longint'(c[11:3]);
    longint v;
    if (c[14:12] == 3'd7)      v = 2 * m;
    else if (c[14:12] == 3'd0) v = m;
    else                       v = 0;
    return c[15] ? -v : v;
  endfunction

  function automatic logic [PW-1:0] model(logic [PW-1:0] pix);
    logic [PW-1:0] res = '0;
    for (int ch = 0; ch < 3; ch++) begin
      longint acc = 0;
      for (int j = 0; j < 3; j++) begin
        longint pre_v = a_pre[j][12] ? longint'(a_pre[j]) - 8192 : longint'(a_pre[j]);
        acc += (8 * longint'(pix[j*CW +: CW]) + pre_v) * coef_val(a_coef[ch][j]);
      end
      acc += 512 * (a_mode[2] ? 64'sd514 : longint'(a_post[ch]));
      acc = (acc + 2048) >>> 12;
      if (acc < 0) acc = 0;
      if (acc > 1023) acc = 1023;
      res[ch*CW +: CW] = CW'(acc);
    end
    return res;
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    if (idx < 6 && idx % 2 == 0) return {s_coef[idx/2][0], s_coef[idx/2][1]};
    if (idx < 6)                 return {s_coef[idx/2][2], 16'h0000};
    if (idx == 6)                return {29'd0, s_mode};
    if (idx < 10)                return {19'd0, s_pre[idx-7]};
    if (idx < 13)                return {19'd0, s_post[idx-10]};
    return 32'h0;
  endfunction

  task automatic tick(bit v, bit en, logic [PW-1:0] pix, string req);
    @(negedge clk);
    check("R2 valid", 64'(out_valid), 64'(hv[2]));
    if (hv[2]) check(hr[2], 64'(out_pix), 64'(hp[2]));
    hv[2] = hv[1]; hp[2] = hp[1]; hr[2] = hr[1];
    hv[1] = hv[0]; hp[1] = hp[0]; hr[1] = hr[0];
    cfg_we = 1'b0; frame_start = 1'b0;
    in_valid = v; in_csc_en = en; in_pix = pix;
    hv[0] = v;
    hp[0] = en ? model(pix) : pix;
    hr[0] = en ? req : "R3 bypass";
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, '0, "");
  endtask

  task automatic wr(int idx, logic [31:0] d);
    tick(1'b0, 1'b0, '0, "");
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    if (idx < 6 && idx % 2 == 0) begin
      s_coef[idx/2][0] = d[31:16]; s_coef[idx/2][1] = d[15:0];
    end else if (idx < 6)  s_coef[idx/2][2] = d[31:16];
    else if (idx == 6)     s_mode = d[2:0];
    else if (idx < 10)     s_pre[idx-7] = d[12:0];
    else if (idx < 13)     s_post[idx-10] = d[12:0];
  endtask

  task automatic rd_check(int idx, string req);
    tick(1'b0, 1'b0, '0, "");
    cfg_idx = 4'(idx);
    #1 check(req, 64'(cfg_rdata), 64'(exp_rd(idx)));
  endtask

  task automatic set_row(int r, logic [15:0] c0, logic [15:0] c1, logic [15:0] c2);
    wr(2*r, {c0, c1});
    wr(2*r + 1, {c2, 16'($urandom)});   // lower half must be dropped
  endtask

  task automatic set_ofs(int ch, logic [12:0] pre, logic [12:0] post);
    wr(7 + ch, {19'($urandom), pre});
    wr(10 + ch, {19'($urandom), post});
  endtask

  task automatic commit();
    idle(4);
    frame_start = 1'b1;
    a_coef = s_coef; a_pre = s_pre; a_post = s_post; a_mode = s_mode;
  endtask

  task automatic stream(int n, string req, int byp_pct);
    for (int i = 0; i < n; i++)
      tick(($urandom % 4) != 0, ($urandom % 100) >= byp_pct, PW'($urandom), req);
  endtask

  function automatic logic [15:0] rand_coef();
    logic [2:0] e;
    case ($urandom % 4)
      0:       e = 3'd0;
      1, 2:    e = 3'd7;
      default: e = 3'($urandom);
    endcase
    return {1'($urandom), e, 12'($urandom)};
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial void'($urandom(32'h5eed_c5c0));

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; frame_start = 1'b0;
    in_valid = 1'b0; in_csc_en = 1'b0; in_pix = '0;
    for (int i = 0; i < 3; i++) begin
      hv[i] = 1'b0; hp[i] = '0; hr[i] = "";
      s_pre[i] = '0; s_post[i] = '0;
      for (int j = 0; j < 3; j++) s_coef[i][j] = (i == j) ? 16'h7800 : 16'h0;
    end
    s_mode = '0;
    a_coef = s_coef; a_pre = s_pre; a_post = s_post; a_mode = s_mode;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    // R1: unity after reset
    for (int i = 0; i < 16; i++) rd_check(i, "R1 reset readback");
    stream(200, "R1 unity", 30);

    // R5 then R10: limited-range compression, staged first
    for (int r = 0; r < 3; r++)
      set_row(r, r == 0 ? 16'h0DB8 : 16'h0, r == 1 ? 16'h0DB8 : 16'h0, r == 2 ? 16'h0DB8 : 16'h0);
    for (int ch = 0; ch < 3; ch++) set_ofs(ch, 13'd0, 13'd514);
    wr(6, 32'h0);
    stream(60, "R5 staged not live", 0);
    commit();
    tick(1'b1, 1'b1, {3{10'd0}}, "R10 black");
    tick(1'b1, 1'b1, {3{10'd1023}}, "R10 white");
    idle(2);
    check("R10 model black", 64'(model({3{10'd0}})), 64'({3{10'd64}}));
    check("R10 model white", 64'(model({3{10'd1023}})), 64'({3{10'd941}}));
    stream(200, "R10 limited", 20);

    // R8: lift from the mode bit, post words zero
    for (int ch = 0; ch < 3; ch++) set_ofs(ch, 13'd0, 13'd0);
    wr(6, 32'hFFFF_FFFC);
    commit();
    stream(150, "R8 black lift", 0);
    wr(6, 32'h3);
    commit();
    stream(100, "R8 mode 1:0 inert", 0);

    // R4: readback map with random data, including unused words
    for (int i = 0; i < 16; i++) wr(i, $urandom);
    for (int i = 0; i < 16; i++) rd_check(i, "R4 readback");

    // R9: saturation both ways
    set_row(0, 16'hF800, 16'h0, 16'h0);
    set_row(1, 16'h0, 16'h7FF8, 16'h0);
    set_row(2, 16'h7800, 16'h0, 16'h7800);
    set_ofs(0, 13'd0, 13'd0); set_ofs(1, 13'd0, 13'd0); set_ofs(2, 13'd0, 13'd8191);
    wr(6, 32'h0);
    commit();
    tick(1'b1, 1'b1, {3{10'd1023}}, "R9 high");
    tick(1'b1, 1'b1, {10'd0, 10'd600, 10'd5}, "R9 mixed");
    stream(200, "R9 saturate", 0);

    // R7: unity matrix with signed pre-offsets and post-offsets
    for (int r = 0; r < 3; r++)
      set_row(r, r == 0 ? 16'h7800 : 16'h0, r == 1 ? 16'h7800 : 16'h0, r == 2 ? 16'h7800 : 16'h0);
    set_ofs(0, 13'h1FF0, 13'd3); set_ofs(1, 13'd100, 13'd4); set_ofs(2, 13'h1000, 13'd4095);
    commit();
    stream(200, "R7 offsets", 10);

    // R6 and R7: random settings
    for (int k = 0; k < 25; k++) begin
      for (int r = 0; r < 3; r++) set_row(r, rand_coef(), rand_coef(), rand_coef());
      for (int ch = 0; ch < 3; ch++) set_ofs(ch, 13'($urandom), 13'($urandom));
      wr(6, ($urandom % 3 == 0) ? 32'h4 : 32'h0);
      commit();
      stream(150, "R6 random coefficients", 15);
    end

    idle(4);
    finish_run();
  end
endmodule